// File: doc/BRIEF.md
# Posted-Write Bus Bridge

This block joins a fast upstream request channel to a slow downstream bus. A write from upstream is taken into an internal FIFO and finishes on its handshake, with no wait for the downstream side. A sequencer then replays the stored writes onto the downstream bus one at a time, in arrival order. Each downstream cycle may wait any number of clocks for its acknowledge.

A read is coupled. Once it is accepted, the bridge takes no further request. It first lets every earlier write finish downstream, then issues the read, and returns the data upstream on a one-cycle response. Software that must know a posted write has landed therefore performs a read. Downstream failures on posted writes have no upstream transaction left to report on, so they raise a separate one-cycle error pulse. A failure on a read comes back as an error bit in that read's response.

Top module: `pwb_bridge`

## Requirements
- R1: Out of reset, up_ready=1, idle=1, dn_valid=0, rsp_valid=0 and wr_err=0. A write presented while the FIFO has room and no read is outstanding is taken in the first cycle it is presented.
- R2: The FIFO stores DEPTH posted writes in addition to the one on the downstream bus. Once it is full, up_ready stays low until an entry drains.
- R3: dn_valid, together with stable dn_write, dn_addr and dn_wdata, is held until the clock edge at which dn_ack is sampled high, however many cycles that takes. dn_valid is low in the cycle that follows the acknowledge.
- R4: A downstream read is issued only after every write accepted before it has been acknowledged downstream. The read therefore returns the value most recently written to that address.
- R5: rsp_valid is high for exactly one cycle, the cycle after the edge at which the read's dn_ack is sampled, and rsp_data then equals the dn_rdata sampled at that edge. No response appears for writes.
- R6: Downstream cycles occur in exactly the order of the upstream handshakes, with the same kind (read or write), the same address and, for writes, the same data.
- R7: From the edge that accepts a read until the response cycle, up_ready is low.
- R8: wr_err is a one-cycle pulse in the cycle after a downstream write acknowledge that had dn_err high. At all other times it is low.
- R9: rsp_err equals the dn_err sampled with the read's acknowledge. The bench's downstream model raises dn_err for every address whose low four bits are 1111.
- R10: idle is high exactly when the FIFO is empty, no downstream cycle is in flight and no read is pending.
- R11: A write accepted at edge k, with an empty FIFO and an idle downstream side, drives dn_valid high from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted this cycle when high with up_valid |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Request address |
| up_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | DW | Read data |
| rsp_err | output | 1 | Downstream error on this read |
| dn_valid | output | 1 | Downstream cycle request |
| dn_write | output | 1 | Downstream cycle is a write |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge, any latency |
| dn_rdata | input | DW | Downstream read data, valid with dn_ack |
| dn_err | input | 1 | Downstream error, valid with dn_ack |
| wr_err | output | 1 | One-cycle flag: a posted write failed downstream |
| idle | output | 1 | No posted write, pending read or downstream cycle left |

## Verification
Three latencies are fixed, counted from the handshake edge k:
- a first write shows dn_valid from edge k+1;
- rsp_valid and wr_err each appear in the one cycle after the edge that samples dn_ack;
- up_ready is low from the edge after a read is accepted until the response cycle.

The bench drives inputs and samples outputs on falling edges, so each check lands in the exact cycle its requirement names. The downstream model raises dn_ack at a falling edge, and the result is checked at the next falling edge against a cycle counter. Order and data are checked against a queue of accepted requests and a shadow memory, both written by the bench when each handshake is seen.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WRITE = 2'd1,
    SQ_READ  = 2'd2
  } sq_state_e;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/pwb_wfifo.sv
module pwb_wfifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int EW = AW + DW;
  localparam int PW = pwb_pkg::ptr_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign {head_addr, head_data} = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |-> !push)
    else $error("write pushed into full FIFO");
endmodule

// File: rtl/pwb_dn_seq.sv
module pwb_dn_seq #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          fifo_pop,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_fin,
  output logic          dn_valid,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_err,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          wr_err
);
  import pwb_pkg::*;

  sq_state_e state;

  // writes always win the idle slot: a read only starts once the FIFO is empty
  assign fifo_pop = (state == SQ_IDLE) && !fifo_empty;
  assign rd_fin   = (state == SQ_READ) && dn_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      dn_valid  <= 1'b0;
      dn_write  <= 1'b0;
      dn_addr   <= '0;
      dn_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      wr_err    <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (!fifo_empty) begin
            dn_valid <= 1'b1;
            dn_write <= 1'b1;
            dn_addr  <= head_addr;
            dn_wdata <= head_data;
            state    <= SQ_WRITE;
          end else if (rd_req) begin
            dn_valid <= 1'b1;
            dn_write <= 1'b0;
            dn_addr  <= rd_addr;
            state    <= SQ_READ;
          end
        end
        SQ_WRITE: begin
          if (dn_ack) begin
            dn_valid <= 1'b0;
            wr_err   <= dn_err;
            state    <= SQ_IDLE;
          end
        end
        SQ_READ: begin
          if (dn_ack) begin
            dn_valid  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= dn_rdata;
            rsp_err   <= dn_err;
            state     <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_write) && $stable(dn_addr) && $stable(dn_wdata)))
    else $error("downstream request changed before acknowledge");

  assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_ack) |=> !dn_valid)
    else $error("downstream request not released after acknowledge");
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          dn_valid,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_err,
  output logic          wr_err,
  output logic          idle
);
  logic          fifo_empty, fifo_full, fifo_pop, push, take_rd;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          rd_pending, rd_fin;
  logic [AW-1:0] rd_addr;

  assign up_ready = !rd_pending && !fifo_full;
  assign push     = up_valid && up_ready && up_write;
  assign take_rd  = up_valid && up_ready && !up_write;
  assign idle     = fifo_empty && !dn_valid && !rd_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pending <= 1'b0;
      rd_addr    <= '0;
    end else if (take_rd) begin
      rd_pending <= 1'b1;
      rd_addr    <= up_addr;
    end else if (rd_fin) begin
      rd_pending <= 1'b0;
    end
  end

  pwb_wfifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(up_addr), .push_data(up_wdata),
    .pop(fifo_pop),
    .head_addr(head_addr), .head_data(head_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  pwb_dn_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .fifo_empty(fifo_empty), .head_addr(head_addr), .head_data(head_data),
    .fifo_pop(fifo_pop),
    .rd_req(rd_pending), .rd_addr(rd_addr), .rd_fin(rd_fin),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_err(dn_err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .wr_err(wr_err)
  );

  assert_read_barrier_R4: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_write) |-> fifo_empty)
    else $error("read issued with posted writes still queued");

  assert_rsp_for_read_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_pending))
    else $error("response without a pending read");
endmodule

// File: tb/sim_pwb_bridge.sv
module sim_pwb_bridge;
  localparam int AW = 16, DW = 32, DEPTH = 4, NREQ = 1200, QN = 2048;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic up_valid, up_ready, up_write, rsp_valid, rsp_err;
  logic [AW-1:0] up_addr, dn_addr;
  logic [DW-1:0] up_wdata, rsp_data, dn_wdata, dn_rdata;
  logic dn_valid, dn_write, dn_ack, dn_err, wr_err, idle;

  pwb_bridge #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_err(dn_err),
    .wr_err(wr_err), .idle(idle));

  int errors = 0, checks = 0;
  int unsigned tick = 0;
  always @(posedge clk) tick <= tick + 1;

  bit            q_w [QN];
  logic [AW-1:0] q_a [QN];
  logic [DW-1:0] q_d [QN];
  int q_head = 0, q_tail = 0;
  logic [DW-1:0] shadow [16];
  logic [DW-1:0] dmem [16];

  int latmax = 3;
  bit stall = 1'b0;
  int unsigned rd_ack_tick = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit err_addr(input logic [AW-1:0] a);
    return a[3:0] == 4'hF;
  endfunction

  // downstream memory model with random acknowledge latency
  initial begin
    bit tracking = 1'b0, wexp = 1'b0;
    bit c_w;
    logic [AW-1:0] c_a;
    logic [DW-1:0] c_d;
    int wait_cnt = 0;
    dn_ack = 1'b0; dn_rdata = '0; dn_err = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (wexp || wr_err) chk(wr_err == wexp, "R8", "wr_err", 64'(wr_err), 64'(wexp));
        wexp = 1'b0;
        if (dn_ack) begin
          chk(!dn_valid, "R3", "dn_valid after ack", 64'(dn_valid), 64'd0);
          dn_ack = 1'b0; dn_err = 1'b0; tracking = 1'b0;
          wait_cnt = int'($urandom_range(latmax, 0));
        end else if (dn_valid) begin
          if (!tracking) begin
            tracking = 1'b1; c_w = dn_write; c_a = dn_addr; c_d = dn_wdata;
          end
          if (!stall && wait_cnt == 0) begin
            chk(dn_write == c_w && dn_addr == c_a && (!c_w || dn_wdata == c_d), "R3",
                "fields held", 64'(dn_addr), 64'(c_a));
            chk(q_head < q_tail, "R6", "unexpected downstream cycle", 64'(q_head), 64'(q_tail));
            if (q_head < q_tail) begin
              chk(q_w[q_head] == dn_write && q_a[q_head] == dn_addr &&
                  (!dn_write || q_d[q_head] == dn_wdata), "R6", "order addr",
                  64'(dn_addr), 64'(q_a[q_head]));
              q_head++;
            end
            dn_ack = 1'b1;
            dn_err = err_addr(dn_addr);
            if (dn_write) begin
              dmem[dn_addr[3:0]] = dn_wdata;
              wexp = dn_err;
            end else begin
              dn_rdata = dmem[dn_addr[3:0]];
              rd_ack_tick = tick;
            end
          end else if (!stall) begin
            wait_cnt--;
          end
        end
      end
    end
  end

  // present one request at a falling edge; returns one falling edge after the handshake
  task automatic send(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, output int waited);
    logic [DW-1:0] exp;
    bit r7_bad = 1'b0;
    int n = 0;
    up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = d;
    waited = 0;
    while (!up_ready && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    q_w[q_tail] = w; q_a[q_tail] = a; q_d[q_tail] = d; q_tail++;
    if (w) shadow[a[3:0]] = d;
    exp = shadow[a[3:0]];
    @(negedge clk);
    up_valid = 1'b0;
    if (!w) begin
      while (!rsp_valid && n < 5000) begin
        if (up_ready) r7_bad = 1'b1;
        @(negedge clk);
        n++;
      end
      chk(!r7_bad, "R7", "up_ready low while read pending", 64'(r7_bad), 64'd0);
      chk(rsp_valid, "R5", "response arrived", 64'(rsp_valid), 64'd1);
      chk(rsp_data == exp, "R4", "read returns latest write", 64'(rsp_data), 64'(exp));
      chk(tick == rd_ack_tick + 1, "R5", "response cycle", 64'(tick), 64'(rd_ack_tick + 1));
      chk(rsp_err == err_addr(a), "R9", "rsp_err", 64'(rsp_err), 64'(err_addr(a)));
      @(negedge clk);
      chk(!rsp_valid, "R5", "single-cycle response", 64'(rsp_valid), 64'd0);
    end else begin
      chk(!rsp_valid, "R5", "no response for write", 64'(rsp_valid), 64'd0);
    end
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!idle && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(idle && !dn_valid && q_head == q_tail, req, "drained to idle", 64'(q_head), 64'(q_tail));
  endtask

  initial begin
    int wt;
    void'($urandom(32'h5EED_0A11));
    up_valid = 1'b0; up_write = 1'b0; up_addr = '0; up_wdata = '0;
    for (int i = 0; i < 16; i++) begin shadow[i] = '0; dmem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(up_ready && idle && !dn_valid && !rsp_valid && !wr_err, "R1", "reset state",
        {59'd0, up_ready, idle, dn_valid, rsp_valid, wr_err}, 64'h18);

    // first write: immediate acceptance and issue latency
    send(1'b1, 16'h0001, 32'hA5A5_0001, wt);
    chk(wt == 0, "R1", "write taken at once", 64'(wt), 64'd0);
    chk(!dn_valid && !idle, "R10", "busy after posting", {62'd0, dn_valid, idle}, 64'd0);
    @(negedge clk);
    chk(dn_valid && dn_write, "R11", "dn_valid one edge after accept", 64'(dn_valid), 64'd1);
    wait_idle("R10");

    // write then read to the same address
    send(1'b1, 16'h0002, 32'h1234_5678, wt);
    send(1'b1, 16'h0003, 32'h0BAD_CAFE, wt);
    send(1'b0, 16'h0002, '0, wt);

    // fill the FIFO with the downstream side stalled
    @(posedge clk); stall = 1'b1; @(negedge clk);
    for (int i = 0; i <= DEPTH; i++) begin
      send(1'b1, AW'(4 + i), 32'hF000_0000 + i, wt);
      chk(wt == 0, "R2", "accepted while room", 64'(wt), 64'd0);
    end
    up_valid = 1'b1; up_write = 1'b1; up_addr = 16'h000A; up_wdata = 32'hDEAD_0000;
    for (int i = 0; i < 8; i++) begin
      chk(!up_ready, "R2", "back-pressure when full", 64'(up_ready), 64'd0);
      @(negedge clk);
    end
    @(posedge clk); stall = 1'b0; @(negedge clk);
    send(1'b1, 16'h000A, 32'hDEAD_0000, wt);
    send(1'b0, 16'h0004, '0, wt);
    wait_idle("R6");

    // error cases
    send(1'b1, 16'h000F, 32'h0000_00EE, wt);
    wait_idle("R8");
    send(1'b0, 16'h000F, '0, wt);
    send(1'b0, 16'h000E, '0, wt);

    // long acknowledge latency
    @(posedge clk); latmax = 40; @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      send(($urandom_range(99, 0) >= 40), AW'($urandom_range(15, 0)), $urandom, wt);
    end
    wait_idle("R3");

    // random mix
    @(posedge clk); latmax = 4; @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      send(($urandom_range(99, 0) >= 35), AW'($urandom_range(15, 0)), $urandom, wt);
      if ($urandom_range(99, 0) < 20) repeat ($urandom_range(3, 1)) @(negedge clk);
    end
    wait_idle("R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule